// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter

This block decides where an error-free received CAN frame goes. A frame descriptor (29-bit identifier, extended-format flag, remote-request flag) enters on a valid/ready stream. Each of sixteen mailboxes is described by a stored identifier, an extended-format flag and a 4-bit mailbox code. From these the block picks either the receive mailbox that should store a data frame, or the transmit mailbox that should answer a remote frame automatically.

Data frames are compared under an acceptance mask. Mailboxes 0 to 13 share a common mask, and the last two mailboxes each have their own. A mask bit of 1 forces the identifier bit to match. A mask bit of 0 makes it a don't-care. Remote frames are never stored. They are compared exactly, with no mask, against mailboxes that hold the auto-response transmit code. All comparisons are combinational. The decision is registered and offered on an output valid/ready stream.

Back-pressure works as follows. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new frame is taken.

Top module: `rx_accept_filter`

## Requirements
- R1: For data frames, a mask bit of 1 requires the frame identifier bit to equal the mailbox identifier bit. A mask bit of 0 makes that bit irrelevant.
- R2: Mailboxes 0..13 use `mask_glb`, mailbox 14 uses `mask_mb14` and mailbox 15 uses `mask_mb15`.
- R3: A standard frame (`frm_ide`=0) compares only identifier bits 28:18. Bits 17:0 of the frame and of the mailbox have no effect.
- R4: An extended frame (`frm_ide`=1) compares all identifier bits 28:0.
- R5: A frame never matches a mailbox whose extended-format flag differs from `frm_ide`.
- R6: Only mailboxes with code 4'b0100 (empty), 4'b0010 (full) or 4'b0110 (overrun) take part in data-frame matching. Every other code is ignored.
- R7: When several mailboxes qualify, the lowest index is reported.
- R8: A remote frame (`frm_rtr`=1) never produces a receive hit. It produces a response hit only for a mailbox with code 4'b1010, the same format flag and an exactly equal identifier (bits 28:18 for standard, 28:0 for extended), with no mask applied.
- R9: A frame accepted on a rising edge (`in_valid` and `in_ready`) has its result on `out_valid`/`res_*` right after that same edge.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, the result holds stable.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: If nothing qualifies, `res_rx_hit` and `res_rsp_hit` are both 0 and `res_idx` is 0. The two hit flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame descriptor valid |
| in_ready | output | 1 | Filter can take a frame |
| frm_id | input | 29 | Received identifier, bits 28:18 are the base part |
| frm_ide | input | 1 | 1 = extended format |
| frm_rtr | input | 1 | 1 = remote frame |
| mb_id_flat | input | 464 | Mailbox identifiers, mailbox n at bits n*29 +: 29 |
| mb_ide | input | 16 | Mailbox extended-format flags |
| mb_code_flat | input | 64 | Mailbox codes, mailbox n at bits n*4 +: 4 |
| mask_glb | input | 29 | Mask for mailboxes 0..13 |
| mask_mb14 | input | 29 | Mask for mailbox 14 |
| mask_mb15 | input | 29 | Mask for mailbox 15 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| res_rx_hit | output | 1 | A receive mailbox takes the data frame |
| res_rsp_hit | output | 1 | A transmit mailbox answers the remote frame |
| res_idx | output | 4 | Winning mailbox index |

## Verification
Some properties are checked on every cycle. The output holds under back-pressure, a result follows each accepted frame, and a remote frame never yields a receive hit. A miss always reports index 0, and the two hit kinds never assert together. Other behaviour depends on mailbox contents, so only the bench scenarios can show it. This covers the mask semantics and which mask belongs to which mailbox, standard versus extended comparison width, rejection on a format mismatch, which codes qualify, lowest-index priority, and exact unmasked remote matching.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam logic [3:0] CODE_RX_EMPTY = 4'b0100;
  localparam logic [3:0] CODE_RX_FULL  = 4'b0010;
  localparam logic [3:0] CODE_RX_OVR   = 4'b0110;
  localparam logic [3:0] CODE_TX_RSP   = 4'b1010;

  function automatic logic code_is_rx(input logic [3:0] c);
    return (c == CODE_RX_EMPTY) || (c == CODE_RX_FULL) || (c == CODE_RX_OVR);
  endfunction
endpackage

// File: rtl/acf_mb_compare.sv
module acf_mb_compare
  import acf_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ide,
  input  logic            frm_rtr,
  input  logic [ID_W-1:0] mb_id,
  input  logic            mb_ide,
  input  logic [3:0]      mb_code,
  input  logic [ID_W-1:0] mask,
  output logic            rx_req,
  output logic            rsp_req
);
  localparam int LOW_W = ID_W - STD_W;

  logic [ID_W-1:0] field_sel;
  logic [ID_W-1:0] diff;
  logic            fmt_eq;

  // extended frames span every bit, standard ones only the base part
  assign field_sel = frm_ide ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {LOW_W{1'b0}}};
  assign diff      = (frm_id ^ mb_id) & field_sel;
  assign fmt_eq    = (frm_ide == mb_ide);

  assign rx_req  = !frm_rtr && code_is_rx(mb_code) && fmt_eq && ((diff & mask) == '0);
  assign rsp_req =  frm_rtr && (mb_code == CODE_TX_RSP) && fmt_eq && (diff == '0);
endmodule

// File: rtl/acf_lowest_pick.sv
module acf_lowest_pick #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import acf_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  parameter int STD_W  = 11,
  parameter int CODE_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ID_W-1:0]          frm_id,
  input  logic                     frm_ide,
  input  logic                     frm_rtr,
  input  logic [NUM_MB*ID_W-1:0]   mb_id_flat,
  input  logic [NUM_MB-1:0]        mb_ide,
  input  logic [NUM_MB*CODE_W-1:0] mb_code_flat,
  input  logic [ID_W-1:0]          mask_glb,
  input  logic [ID_W-1:0]          mask_mb14,
  input  logic [ID_W-1:0]          mask_mb15,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     res_rx_hit,
  output logic                     res_rsp_hit,
  output logic [IDX_W-1:0]         res_idx
);
  logic [NUM_MB-1:0] rx_req, rsp_req;
  logic              rx_any, rsp_any;
  logic [IDX_W-1:0]  rx_idx, rsp_idx, nxt_idx;
  logic              take;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic [ID_W-1:0] sel_mask;
    if (g < NUM_MB - 2) begin : g_glb
      assign sel_mask = mask_glb;
    end else if (g == NUM_MB - 2) begin : g_own_a
      assign sel_mask = mask_mb14;
    end else begin : g_own_b
      assign sel_mask = mask_mb15;
    end

    acf_mb_compare #(.ID_W(ID_W), .STD_W(STD_W)) u_cmp (
      .frm_id  (frm_id),
      .frm_ide (frm_ide),
      .frm_rtr (frm_rtr),
      .mb_id   (mb_id_flat[g*ID_W +: ID_W]),
      .mb_ide  (mb_ide[g]),
      .mb_code (mb_code_flat[g*CODE_W +: 4]),
      .mask    (sel_mask),
      .rx_req  (rx_req[g]),
      .rsp_req (rsp_req[g])
    );
  end

  acf_lowest_pick #(.N(NUM_MB), .IDX_W(IDX_W)) u_pick_rx (
    .req(rx_req), .hit(rx_any), .idx(rx_idx)
  );
  acf_lowest_pick #(.N(NUM_MB), .IDX_W(IDX_W)) u_pick_rsp (
    .req(rsp_req), .hit(rsp_any), .idx(rsp_idx)
  );

  assign nxt_idx  = rx_any ? rx_idx : (rsp_any ? rsp_idx : '0);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_rx_hit  <= 1'b0;
      res_rsp_hit <= 1'b0;
      res_idx     <= '0;
    end else if (take) begin
      out_valid   <= 1'b1;
      res_rx_hit  <= rx_any;
      res_rsp_hit <= rsp_any;
      res_idx     <= nxt_idx;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R10
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_idx)
      && $stable(res_rx_hit) && $stable(res_rsp_hit));

  // R9
  result_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  remote_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && frm_rtr |=> !res_rx_hit);

  // R12
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !res_rx_hit && !res_rsp_hit |-> res_idx == '0);

  // R12
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_rx_hit && res_rsp_hit));

  // R7
  rx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_any |-> rx_req[rx_idx] && ((rx_req & ((NUM_MB'(1) << rx_idx) - NUM_MB'(1))) == '0));
endmodule

// File: tb/rx_accept_filter_bench.sv
module rx_accept_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, res_rx_hit, res_rsp_hit;
  logic [3:0]  res_idx;
  logic [28:0] frm_id = '0;
  logic        frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] mbid [16];
  logic [3:0]  mbcode [16];
  logic [15:0] mb_ide = '0;
  logic [28:0] mask_glb = '1, mask_mb14 = '1, mask_mb15 = '1;
  logic [16*29-1:0] mb_id_flat;
  logic [16*4-1:0]  mb_code_flat;

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      mb_id_flat[i*29 +: 29] = mbid[i];
      mb_code_flat[i*4 +: 4] = mbcode[i];
    end
  end

  rx_accept_filter u_rx_accept_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
    .mb_id_flat(mb_id_flat), .mb_ide(mb_ide), .mb_code_flat(mb_code_flat),
    .mask_glb(mask_glb), .mask_mb14(mask_mb14), .mask_mb15(mask_mb15),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_rx_hit(res_rx_hit), .res_rsp_hit(res_rsp_hit), .res_idx(res_idx)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [5:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: pushes expected {rx,rsp,idx} and offers the frame
  task automatic send(input logic [28:0] id, input bit ide, input bit rtr,
                      input bit erx, input bit ersp, input int eidx, input string tag);
    @(negedge clk);
    frm_id = id; frm_ide = ide; frm_rtr = rtr; in_valid = 1'b1;
    #1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({erx, ersp, eidx[3:0]});
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: scoreboard pop on every delivered result
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", {res_rx_hit, res_rsp_hit, res_idx}, 0);
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({res_rx_hit, res_rsp_hit, res_idx} == e, t,
            {res_rx_hit, res_rsp_hit, res_idx}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [17:0] ALT = 18'b010101010101010101;
  localparam logic [28:0] X3  = {11'b11111111000, ALT};

  initial begin
    for (int i = 0; i < 16; i++) begin mbid[i] = '0; mbcode[i] = 4'b0000; end
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);

    // R4: full-width extended compare
    mbid[3] = X3; mb_ide[3] = 1'b1; mbcode[3] = 4'b0100;
    send(X3, 1, 0, 1, 0, 3, "R4 exact extended hit");
    send(X3 ^ 29'h20, 1, 0, 0, 0, 0, "R4 low extended bit differs");

    // R1: mask semantics
    mask_glb = {11'b11111111110, 18'b111111100000000001};
    send({11'b11111111001, ALT}, 1, 0, 1, 0, 3, "R1 masked-out base bit ignored");
    send({11'b11111111000, 18'b010101010101010100}, 1, 0, 0, 0, 0, "R1 masked-in bit 0 differs");
    send(X3 ^ 29'h400, 1, 0, 1, 0, 3, "R1 masked-out bit 10 ignored");

    // R3: standard compares base only
    mbid[2] = {11'b11111111000, 18'b0}; mb_ide[2] = 1'b0; mbcode[2] = 4'b0100;
    send({11'b11111111001, 18'b101010101010101010}, 0, 0, 1, 0, 2, "R3 low bits ignored");
    send({11'b11111101000, 18'b0}, 0, 0, 0, 0, 0, "R3 base bit compared");

    // R5: format mismatch
    send({11'b11111111000, 18'b0}, 1, 0, 0, 0, 0, "R5 extended vs standard mailbox");
    mbcode[2] = 4'b0000;
    send(X3, 0, 0, 0, 0, 0, "R5 standard vs extended mailbox");

    // R2: per-index masks
    mbid[14] = X3; mb_ide[14] = 1'b1; mbcode[14] = 4'b0100;
    mask_mb14 = {11'b01111111111, 18'b0};
    send({11'b01111111000, ALT}, 1, 0, 1, 0, 14, "R2 own mask on mailbox 14");
    mbid[15] = '0; mb_ide[15] = 1'b1; mbcode[15] = 4'b0100; mask_mb15 = '0;
    send({11'b00000000111, 18'b1}, 1, 0, 1, 0, 15, "R2 own mask on mailbox 15");

    // R7: lowest index wins
    send(X3, 1, 0, 1, 0, 3, "R7 lowest of 3,14,15");

    // R6: participating codes
    mbcode[3] = 4'b0010; send(X3, 1, 0, 1, 0, 3, "R6 full code takes part");
    mbcode[3] = 4'b0110; send(X3, 1, 0, 1, 0, 3, "R6 overrun code takes part");
    mbcode[3] = 4'b0000; send(X3, 1, 0, 1, 0, 14, "R6 inactive code ignored");
    mbcode[3] = 4'b1000; send(X3, 1, 0, 1, 0, 14, "R6 transmit code ignored");

    // R8: remote frames
    mbid[5] = {11'b00000011101, 18'b0}; mb_ide[5] = 1'b0; mbcode[5] = 4'b1010;
    mbid[4] = {11'b00000011101, 18'b0}; mb_ide[4] = 1'b0; mbcode[4] = 4'b0100;
    send({11'b00000011101, 18'h155}, 0, 1, 0, 1, 5, "R8 remote exact answers");
    send({11'b00000011100, 18'b0}, 0, 1, 0, 0, 0, "R8 remote ignores mask");
    send({11'b00000011101, 18'b0}, 0, 0, 1, 0, 4, "R8 data frame stored not answered");
    send({11'b00000011101, 18'b0}, 1, 1, 0, 0, 0, "R8 remote format mismatch");

    // R9 / R10: latency and back-pressure
    @(posedge clk); #2 out_ready = 1'b0;
    send({11'b00000011101, 18'b0}, 0, 0, 1, 0, 4, "R10 held result delivered");
    chk(out_valid == 1'b1, "R9 result after accept", out_valid, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && !in_ready && res_idx == 4'd4 && res_rx_hit,
          "R10 hold under back-pressure", {out_valid, in_ready, res_idx}, {1'b1, 1'b0, 4'd4});
    end
    fork
      send({11'b00000011101, 18'b0}, 0, 1, 0, 1, 5, "R10 frame after release");
      begin repeat (2) @(posedge clk); #2 out_ready = 1'b1; end
    join

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule